// File: doc/BRIEF.md
# First-Error Capture and Logging Unit

This unit keeps the error record for a packet-processing engine. A detector outside the block presents a vector of error strobes, one bit per error kind, together with the header fields of the packet being processed (command, supplementary, source, address) and, when the packet has one, its data flit. Each strobe sets a sticky bit in an 11-bit status vector. The interrupt output is high whenever any status bit is set.

The first error that arrives while the capture record is empty freezes that packet's header and data in the capture registers, marks the record valid and stores the index of the error kind. Later errors only raise an overrun flag. The clock-drop error is exempt from capture. Software reads every register through a simple port and can clear status bits selectively. It can also write the status vector and the capture registers directly to simulate an error.

Top module: `errlog_unit`

## Requirements
- R1: Status bit i is set by error strobe i. From bit 0 upward the bits are: request bad command, reply bad command, request short, reply short, request long, reply long, request bad data, reply bad data, request bad address, request bad invalidate, clock drop (bit 10). The vector reads at register address 0, bits 10:0.
- R2: Status bits stay set until cleared. Reading any register changes no state. The status vector is not cleared by reset.
- R3: A write to address 1 clears exactly the status bits that are 1 in write data bits 10:0 and leaves the others unchanged. An error strobe in the same cycle still sets its bit.
- R4: A write to address 0 replaces the status vector with write data bits 10:0. The irq output is 1 exactly when at least one status bit is 1.
- R5: When any error strobe other than clock drop is high while the valid flag is 0, the command, supplementary, source and address inputs are captured, valid is set, and the error-type field is set to the bit index of the error. If only one such strobe is high, overrun is cleared.
- R6: When any error strobe other than clock drop is high while valid is 1, overrun is set and the captured command, supplementary, source, type and address fields keep their values.
- R7: A clock-drop strobe sets status bit 10 and leaves the type, valid and overrun fields unchanged.
- R8: The header word at address 2 holds command in bits 6:0, supplementary in 18:8, source in 30:20, type in 35:32, overrun in bit 40 and valid in bit 44, with all other bits 0. Address 3 holds the 38-bit captured address. Software writes to addresses 2, 3 and 4 load those registers directly.
- R9: The data register at address 4 is loaded from the data input only on a capture (valid was 0) whose packet carries a data flit. Otherwise it keeps its value.
- R10: When several non-clock-drop strobes are high in one cycle with valid at 0, the lowest-numbered one gives the type field and overrun is set.
- R11: Reset clears the header word, address and data registers. Address 1 reads as 0. Writes take effect at the next rising clock edge, and reads return the register contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_vec | input | 11 | Error strobes, one per error kind |
| evt_cmd | input | 7 | Command field of the current packet header |
| evt_sup | input | 11 | Supplementary field of the current header |
| evt_src | input | 11 | Source field of the current header |
| evt_addr | input | 38 | Address field of the current header |
| evt_has_data | input | 1 | Current packet carries a data flit |
| evt_data | input | 64 | Data flit of the current packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Every result of an error strobe or a register write sits in a single register stage. Status, irq, the header word, the address and the data are therefore all visible right after the rising edge that samples the stimulus, and read data follows reg_addr with no clock. The bench applies each strobe or write at a falling edge and holds it through one rising edge. It then samples one nanosecond later, after setting reg_addr while the clock is steady. Reset release passes through a two-stage synchronizer, so the bench waits several edges after raising rst_n before it checks the retained status and the cleared capture record.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int ERR_N       = 11;
  localparam int CLKDROP_IDX = ERR_N - 1;
  localparam int TYPE_W      = 4;
  localparam int REG_W       = 64;
  localparam int RSEL_W      = 3;

  // header word field positions (software decodes these)
  localparam int HB_CMD_LO  = 0;
  localparam int HB_SUP_LO  = 8;
  localparam int HB_SRC_LO  = 20;
  localparam int HB_TYPE_LO = 32;
  localparam int HB_OVR     = 40;
  localparam int HB_VLD     = 44;

  typedef enum logic [RSEL_W-1:0] {
    RA_STATUS  = 3'd0,
    RA_MASKCLR = 3'd1,
    RA_HDR     = 3'd2,
    RA_ADDR    = 3'd3,
    RA_DATA    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/errlog_status.sv
module errlog_status #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         wr_set,
  input  logic [N-1:0] set_val,
  input  logic         wr_clr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] evt,
  output logic [N-1:0] status_q
);
  logic [N-1:0] status_d;
  logic         status_en;

  always_comb begin
    status_d = status_q;
    if (wr_set) status_d = set_val;
    if (wr_clr) status_d = status_d & ~clr_mask;
    status_d  = status_d | evt;
    status_en = wr_set | wr_clr | (|evt);
  end

  // deliberately without reset: contents are retained across reset
  always_ff @(posedge clk) begin
    if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
  import errlog_pkg::*;
#(
  parameter int N      = 11,
  parameter int CMD_W  = 7,
  parameter int SUP_W  = 11,
  parameter int SRC_W  = 11,
  parameter int ADDR_W = 38,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [SUP_W-1:0]  in_sup,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_has_data,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hdr_wr,
  input  logic              adr_wr,
  input  logic              dat_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  hdr_word,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  localparam int NC_W = N - 1;
  localparam logic [NC_W-1:0] NC_ONE = NC_W'(1);

  logic [NC_W-1:0]   nc;
  logic              any_nc, multi_nc, take;
  logic [TYPE_W-1:0] typ_sel;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [SUP_W-1:0]  sup_q, sup_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [TYPE_W-1:0] typ_q, typ_d;
  logic              ovr_q, ovr_d, vld_q, vld_d, hdr_en;
  logic [ADDR_W-1:0] adr_d;
  logic              adr_en;
  logic [DATA_W-1:0] dat_d;
  logic              dat_en;

  // lowest-index non-clock-drop error wins
  always_comb begin
    nc       = evt[NC_W-1:0];
    any_nc   = |nc;
    multi_nc = |(nc & (nc - NC_ONE));
    typ_sel  = '0;
    for (int i = NC_W - 1; i >= 0; i--) begin
      if (nc[i]) typ_sel = TYPE_W'(i);
    end
    take = any_nc & ~vld_q;
  end

  always_comb begin
    cmd_d = cmd_q; sup_d = sup_q; src_d = src_q;
    typ_d = typ_q; ovr_d = ovr_q; vld_d = vld_q;
    hdr_en = 1'b0;
    if (hdr_wr) begin
      cmd_d  = wdata[HB_CMD_LO +: CMD_W];
      sup_d  = wdata[HB_SUP_LO +: SUP_W];
      src_d  = wdata[HB_SRC_LO +: SRC_W];
      typ_d  = wdata[HB_TYPE_LO +: TYPE_W];
      ovr_d  = wdata[HB_OVR];
      vld_d  = wdata[HB_VLD];
      hdr_en = 1'b1;
    end else if (take) begin
      cmd_d  = in_cmd;
      sup_d  = in_sup;
      src_d  = in_src;
      typ_d  = typ_sel;
      ovr_d  = multi_nc;
      vld_d  = 1'b1;
      hdr_en = 1'b1;
    end else if (any_nc) begin
      ovr_d  = 1'b1;
      hdr_en = 1'b1;
    end

    adr_d  = adr_wr ? wdata[ADDR_W-1:0] : in_addr;
    adr_en = adr_wr | take;
    dat_d  = dat_wr ? wdata[DATA_W-1:0] : in_data;
    dat_en = dat_wr | (take & in_has_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; sup_q <= '0; src_q <= '0;
      typ_q <= '0; ovr_q <= 1'b0; vld_q <= 1'b0;
    end else if (hdr_en) begin
      cmd_q <= cmd_d; sup_q <= sup_d; src_q <= src_d;
      typ_q <= typ_d; ovr_q <= ovr_d; vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_addr <= '0;
    else if (adr_en) cap_addr <= adr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_data <= '0;
    else if (dat_en) cap_data <= dat_d;
  end

  always_comb begin
    hdr_word = '0;
    hdr_word[HB_CMD_LO +: CMD_W]   = cmd_q;
    hdr_word[HB_SUP_LO +: SUP_W]   = sup_q;
    hdr_word[HB_SRC_LO +: SRC_W]   = src_q;
    hdr_word[HB_TYPE_LO +: TYPE_W] = typ_q;
    hdr_word[HB_OVR]               = ovr_q;
    hdr_word[HB_VLD]               = vld_q;
  end
endmodule

// File: rtl/errlog_regif.sv
module errlog_regif
  import errlog_pkg::*;
#(
  parameter int N      = 11,
  parameter int ADDR_W = 38,
  parameter int DATA_W = 64
) (
  input  logic              reg_wr,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [N-1:0]      status_q,
  input  logic [REG_W-1:0]  hdr_word,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output logic              st_wr,
  output logic              clr_wr,
  output logic              hdr_wr,
  output logic              adr_wr,
  output logic              dat_wr,
  output logic [REG_W-1:0]  reg_rdata
);
  reg_sel_e sel;

  always_comb begin
    sel    = reg_sel_e'(reg_addr);
    st_wr  = reg_wr & (sel == RA_STATUS);
    clr_wr = reg_wr & (sel == RA_MASKCLR);
    hdr_wr = reg_wr & (sel == RA_HDR);
    adr_wr = reg_wr & (sel == RA_ADDR);
    dat_wr = reg_wr & (sel == RA_DATA);
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_STATUS: reg_rdata[N-1:0]      = status_q;
      RA_HDR:    reg_rdata             = hdr_word;
      RA_ADDR:   reg_rdata[ADDR_W-1:0] = cap_addr;
      RA_DATA:   reg_rdata[DATA_W-1:0] = cap_data;
      default:   reg_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
  import errlog_pkg::*;
#(
  parameter int CMD_W  = 7,
  parameter int SUP_W  = 11,
  parameter int SRC_W  = 11,
  parameter int ADDR_W = 38,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_N-1:0]  evt_vec,
  input  logic [CMD_W-1:0]  evt_cmd,
  input  logic [SUP_W-1:0]  evt_sup,
  input  logic [SRC_W-1:0]  evt_src,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_has_data,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              reg_wr,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [ERR_N-1:0]  status_q;
  logic [REG_W-1:0]  hdr_word;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              st_wr, clr_wr, hdr_wr, adr_wr, dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  errlog_regif #(.N(ERR_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .status_q(status_q),
    .hdr_word(hdr_word), .cap_addr(cap_addr), .cap_data(cap_data),
    .st_wr(st_wr), .clr_wr(clr_wr), .hdr_wr(hdr_wr), .adr_wr(adr_wr),
    .dat_wr(dat_wr), .reg_rdata(reg_rdata)
  );

  errlog_status #(.N(ERR_N)) u_status (
    .clk(clk), .wr_set(st_wr), .set_val(reg_wdata[ERR_N-1:0]),
    .wr_clr(clr_wr), .clr_mask(reg_wdata[ERR_N-1:0]), .evt(evt_vec),
    .status_q(status_q)
  );

  errlog_capture #(.N(ERR_N), .CMD_W(CMD_W), .SUP_W(SUP_W), .SRC_W(SRC_W),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt_vec), .in_cmd(evt_cmd),
    .in_sup(evt_sup), .in_src(evt_src), .in_addr(evt_addr),
    .in_has_data(evt_has_data), .in_data(evt_data), .hdr_wr(hdr_wr),
    .adr_wr(adr_wr), .dat_wr(dat_wr), .wdata(reg_wdata),
    .hdr_word(hdr_word), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  assign irq = |status_q;
endmodule

// File: rtl/errlog_chk.sv
module errlog_chk
  import errlog_pkg::*;
#(
  parameter int N     = 11,
  parameter int CMD_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      evt_vec,
  input logic              reg_wr,
  input logic [RSEL_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [N-1:0]      status_q,
  input logic [REG_W-1:0]  hdr_word,
  input logic              irq
);
  logic any_nc, hdr_w, unused_bits;
  assign any_nc      = |evt_vec[N-2:0];
  assign hdr_w       = reg_wr && (reg_addr == RA_HDR);
  assign unused_bits = ^{reg_wdata[REG_W-1:N], hdr_word[REG_W-1:HB_VLD+1]};

  assert_evt_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  assert_maskclr_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_MASKCLR && evt_vec == '0) |=>
      (((status_q & $past(reg_wdata[N-1:0])) == '0) &&
       ((status_q | $past(reg_wdata[N-1:0])) ==
        ($past(status_q) | $past(reg_wdata[N-1:0])))));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(reg_wr && reg_addr == RA_STATUS) || $past(|evt_vec)));

  assert_capture_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_word[HB_VLD] && any_nc && !hdr_w) |=> hdr_word[HB_VLD]);

  assert_overrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_word[HB_VLD] && any_nc && !hdr_w) |=>
      (hdr_word[HB_OVR] &&
       hdr_word[HB_VLD-1:HB_CMD_LO] [HB_TYPE_LO+TYPE_W-1:0] ==
         $past(hdr_word[HB_TYPE_LO+TYPE_W-1:0])));

  assert_clkdrop_exempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec == (N'(1) << CLKDROP_IDX) && !hdr_w) |=>
      $stable(hdr_word[HB_VLD:HB_TYPE_LO]));
endmodule

bind errlog_unit errlog_chk #(.N(errlog_pkg::ERR_N), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .evt_vec(evt_vec), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_q(status_q),
  .hdr_word(hdr_word), .irq(irq)
);

// File: tb/errlog_unit_tb.sv
module errlog_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] evt_vec;
  logic [6:0]  evt_cmd;
  logic [10:0] evt_sup, evt_src;
  logic [37:0] evt_addr;
  logic        evt_has_data;
  logic [63:0] evt_data;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  errlog_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .evt_cmd(evt_cmd),
    .evt_sup(evt_sup), .evt_src(evt_src), .evt_addr(evt_addr),
    .evt_has_data(evt_has_data), .evt_data(evt_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // op: 0 error event, 1 status write, 2 mask-clear write, 3 header write of 0
  typedef struct packed {
    logic [1:0]  op;
    logic        dat;
    logic [10:0] val;
    logic [10:0] est;
    logic        ev;
    logic        eo;
    logic [3:0]  et;
    logic [6:0]  ec;
    logic [15:0] ed;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{2'd0, 1'b0, 11'h400, 11'h400, 1'b0, 1'b0, 4'd0, 7'h00, 16'h0000},
    '{2'd0, 1'b1, 11'h020, 11'h420, 1'b1, 1'b0, 4'd5, 7'h11, 16'hD001},
    '{2'd0, 1'b0, 11'h004, 11'h424, 1'b1, 1'b1, 4'd5, 7'h11, 16'hD001},
    '{2'd0, 1'b0, 11'h400, 11'h424, 1'b1, 1'b1, 4'd5, 7'h11, 16'hD001},
    '{2'd2, 1'b0, 11'h404, 11'h020, 1'b1, 1'b1, 4'd5, 7'h11, 16'hD001},
    '{2'd3, 1'b0, 11'h000, 11'h020, 1'b0, 1'b0, 4'd0, 7'h00, 16'hD001},
    '{2'd0, 1'b0, 11'h108, 11'h128, 1'b1, 1'b1, 4'd3, 7'h16, 16'hD001},
    '{2'd3, 1'b0, 11'h000, 11'h128, 1'b0, 1'b0, 4'd0, 7'h00, 16'hD001},
    '{2'd0, 1'b1, 11'h600, 11'h728, 1'b1, 1'b0, 4'd9, 7'h18, 16'hD008},
    '{2'd1, 1'b0, 11'h001, 11'h001, 1'b1, 1'b0, 4'd9, 7'h18, 16'hD008},
    '{2'd2, 1'b0, 11'h7FF, 11'h000, 1'b1, 1'b0, 4'd9, 7'h18, 16'hD008}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic fire(input logic [10:0] v, input logic d, input int i);
    @(negedge clk);
    evt_vec = v; evt_has_data = d;
    evt_cmd = 7'(16 + i); evt_sup = 11'(256 + i); evt_src = 11'(512 + i);
    evt_addr = 38'(4096 + i); evt_data = 64'(53248 + i);
    @(posedge clk);
    #1 evt_vec = '0; evt_has_data = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d, h;
    rst_n = 1'b0; evt_vec = '0; evt_cmd = '0; evt_sup = '0; evt_src = '0;
    evt_addr = '0; evt_has_data = 1'b0; evt_data = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11: capture registers cleared by reset
    rd(3'd2, d); chk("R11 reset header word", d, 64'h0);
    rd(3'd3, d); chk("R11 reset address", d, 64'h0);
    rd(3'd4, d); chk("R11 reset data", d, 64'h0);
    wr(3'd1, 64'h7FF);
    rd(3'd0, d); chk("R3 initial clear status", d, 64'h0);
    chk("R4 irq low when status empty", {63'h0, irq}, 64'h0);

    // table walk: R1 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 11; i++) begin
      case (TBL[i].op)
        2'd0: fire(TBL[i].val, TBL[i].dat, i);
        2'd1: wr(3'd0, 64'(TBL[i].val));
        2'd2: wr(3'd1, 64'(TBL[i].val));
        default: wr(3'd2, 64'h0);
      endcase
      rd(3'd0, d); chk($sformatf("R1 R3 R4 status step %0d", i), d, 64'(TBL[i].est));
      chk($sformatf("R4 irq step %0d", i), {63'h0, irq}, {63'h0, (TBL[i].est != 0)});
      rd(3'd2, h);
      chk($sformatf("R5 R7 valid step %0d", i), {63'h0, h[44]}, {63'h0, TBL[i].ev});
      chk($sformatf("R6 R10 overrun step %0d", i), {63'h0, h[40]}, {63'h0, TBL[i].eo});
      chk($sformatf("R5 R10 type step %0d", i), 64'(h[35:32]), 64'(TBL[i].et));
      chk($sformatf("R5 R6 command step %0d", i), 64'(h[6:0]), 64'(TBL[i].ec));
      rd(3'd4, d); chk($sformatf("R9 data step %0d", i), d, 64'(TBL[i].ed));
    end

    // R8: remaining captured fields of the step-8 capture
    rd(3'd3, d); chk("R8 captured address", d, 64'h1008);
    rd(3'd2, h);
    chk("R8 supplementary field", 64'(h[18:8]), 64'h108);
    chk("R8 source field", 64'(h[30:20]), 64'h208);
    chk("R8 unused header bits zero", h & ~64'h0000_110F_7FF7_FF7F, 64'h0);
    rd(3'd1, d); chk("R11 mask-clear reads zero", d, 64'h0);

    // R1: each strobe sets its own bit
    for (int b = 0; b < 11; b++) begin
      wr(3'd1, 64'h7FF);
      fire(11'(1 << b), 1'b0, 40 + b);
      rd(3'd0, d); chk($sformatf("R1 strobe %0d sets bit", b), d, 64'(1 << b));
    end

    // R8 software header write, then R6 overrun on a valid record
    wr(3'd2, 64'h0000_100A_03C0_2B55);
    rd(3'd2, d); chk("R8 header written by software", d, 64'h0000_100A_03C0_2B55);
    wr(3'd4, 64'hCAFE_0000_1234_5678);
    fire(11'h002, 1'b1, 60);
    rd(3'd2, d); chk("R6 overrun set fields kept", d, 64'h0000_110A_03C0_2B55);
    rd(3'd4, d); chk("R9 data kept when valid was 1", d, 64'hCAFE_0000_1234_5678);
    wr(3'd3, 64'h15_5555_5555);
    rd(3'd3, d); chk("R8 address written by software", d, 64'h15_5555_5555);

    // R2: reads do not disturb, status survives reset
    wr(3'd0, 64'h155);
    rd(3'd0, d); rd(3'd0, d); chk("R2 status after repeated reads", d, 64'h155);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rd(3'd0, d); chk("R2 status retained over reset", d, 64'h155);
    chk("R4 irq high with retained status", {63'h0, irq}, 64'h1);
    rd(3'd2, d); chk("R11 header word cleared by reset", d, 64'h0);
    // R3 event wins over same-cycle clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 64'h7FF; evt_vec = 11'h400;
    @(posedge clk);
    #1 reg_wr = 1'b0; evt_vec = '0;
    rd(3'd0, d); chk("R3 strobe beats same-cycle clear", d, 64'h400);
    rd(3'd2, d); chk("R7 clock drop leaves record empty", d, 64'h0);

    finish_run();
  end
endmodule